// File: doc/BRIEF.md
# Ordered Load/Store Address Generator

This block computes effective addresses for memory instructions waiting in reservation stations of an out-of-order core. It forces address generation into program order. A candidate load or store is accepted into a single holding slot. It then waits there until no older memory instruction in the reorder buffer (ROB) is still missing its address. Once the gate opens, base plus offset is produced together with a one-cycle valid pulse and a request to set the candidate's address-computed flag.

Stores are also handled as they are examined. In the first cycle after acceptance, a store writes its data operand into its ROB entry and marks that entry ready, whether or not the address gate is open. When the address appears later, the store also writes it into the same ROB entry. The ROB state is observed through per-entry vectors: busy, is-memory, address-computed and issue number. Memory access and data disambiguation are handled elsewhere.

Top module: `ls_addr_gen`

## Requirements
- R1: After reset, cand_ready_o is 1 and addr_valid_o, addr_done_set_o, rob_addr_we_o, rob_val_we_o and rob_ready_set_o are all 0.
- R2: The effective address on addr_o is cand_base_i plus cand_offset_i, taken modulo 2^ADDR_W, so a carry out of the top bit is dropped.
- R3: A held candidate is blocked while any ROB entry meets all of these conditions: busy is 1, is-memory is 1, address-computed is 0, its index differs from the candidate's index, and its issue number is unsigned-less than the candidate's. Entries that fail any one condition (including an equal issue number) never block.
- R4: A candidate that is not blocked in a held cycle produces addr_valid_o for exactly one cycle, right after that cycle's rising edge. In the same cycle, addr_done_set_o is 1 and addr_done_idx_o carries the candidate's ROB index.
- R5: In the first cycle after a store is accepted, rob_val_we_o and rob_ready_set_o are 1, with rob_val_idx_o equal to the store's index and rob_val_o equal to its data. This happens even if the store is blocked. Loads never raise them, and neither does any later held cycle.
- R6: rob_addr_we_o is 1 together with addr_valid_o for stores only, and addr_o is then the address to write into entry addr_done_idx_o.
- R7: A blocked candidate keeps its operands. Changes to the cand_* inputs while cand_ready_o is 0 have no effect on the produced address, index or store data.
- R8: cand_ready_o is 0 from the edge that accepts a candidate (cand_valid_i and cand_ready_o both 1) until that candidate's address is produced. It is 1 again in the cycle where addr_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Candidate offered |
| cand_ready_o | output | 1 | Holding slot free; an offer is taken at the edge |
| cand_is_store_i | input | 1 | 1 = store, 0 = load |
| cand_idx_i | input | IDX_W (3) | ROB index of candidate |
| cand_base_i | input | ADDR_W (32) | Base register value |
| cand_offset_i | input | ADDR_W (32) | Offset |
| cand_issue_i | input | ISSUE_W (8) | Issue number of candidate |
| cand_data_i | input | DATA_W (32) | Store data |
| rob_busy_i | input | DEPTH (8) | Per-entry busy |
| rob_is_mem_i | input | DEPTH (8) | Per-entry load/store flag |
| rob_addr_done_i | input | DEPTH (8) | Per-entry address-computed flag |
| rob_issue_i | input | DEPTH x ISSUE_W | Per-entry issue number |
| addr_valid_o | output | 1 | Address-produced pulse |
| addr_o | output | ADDR_W | Effective address |
| addr_done_set_o | output | 1 | Set address-computed flag |
| addr_done_idx_o | output | IDX_W | Entry whose flag is set and which receives a store address |
| rob_addr_we_o | output | 1 | Store address write into ROB |
| rob_val_we_o | output | 1 | Store value write into ROB |
| rob_ready_set_o | output | 1 | Mark ROB entry ready |
| rob_val_idx_o | output | IDX_W | Entry for value write and ready mark |
| rob_val_o | output | DATA_W | Store value |

## Verification
A candidate is taken at a rising edge, and its store value write and ready mark are due during the very next cycle. The address pulse follows one rising edge after the first held cycle in which the gate is open. For an unblocked candidate that is two edges after acceptance, and for a blocked one it is one edge after the cycle in which the blocking ROB entries show their address computed. The bench drives and samples at the falling edge, so it checks each result in exactly the cycle it is due. Every waiting cycle is checked for the absence of the pulse, and the cycle after the pulse is checked for its return to zero.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic {MEM_LOAD = 1'b0, MEM_STORE = 1'b1} mem_kind_e;
endpackage

// File: rtl/ls_order_gate.sv
module ls_order_gate #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 8,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]              busy_i,
  input  logic [DEPTH-1:0]              is_mem_i,
  input  logic [DEPTH-1:0]              done_i,
  input  logic [DEPTH-1:0][ISSUE_W-1:0] issue_i,
  input  logic [IDX_W-1:0]              own_idx_i,
  input  logic [ISSUE_W-1:0]            own_issue_i,
  output logic                          pending_o
);
  logic [DEPTH-1:0] older_open;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign older_open[e] = busy_i[e] && is_mem_i[e] && !done_i[e] &&
                           (own_idx_i != IDX_W'(e)) &&
                           (issue_i[e] < own_issue_i);
  end

  assign pending_o = |older_open;
endmodule

// File: rtl/ls_cand_hold.sv
module ls_cand_hold
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ISSUE_W = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               clear_i,
  input  mem_kind_e          kind_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  off_i,
  input  logic [ISSUE_W-1:0] issue_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               vld_o,
  output logic               first_o,
  output mem_kind_e          kind_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [ADDR_W-1:0]  off_o,
  output logic [ISSUE_W-1:0] issue_o,
  output logic [DATA_W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      first_o <= 1'b0;
    end else begin
      first_o <= load_i;
      if (load_i)       vld_o <= 1'b1;
      else if (clear_i) vld_o <= 1'b0;
    end
  end

  // operands only move on acceptance; retained while blocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= MEM_LOAD;
      idx_o   <= '0;
      base_o  <= '0;
      off_o   <= '0;
      issue_o <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      kind_o  <= kind_i;
      idx_o   <= idx_i;
      base_o  <= base_i;
      off_o   <= off_i;
      issue_o <= issue_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/ls_eff_addr.sv
module ls_eff_addr #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] sum_o
);
  assign sum_o = base_i + off_i;  // carry dropped
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_agu_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ISSUE_W = 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cand_valid_i,
  output logic                          cand_ready_o,
  input  logic                          cand_is_store_i,
  input  logic [IDX_W-1:0]              cand_idx_i,
  input  logic [ADDR_W-1:0]             cand_base_i,
  input  logic [ADDR_W-1:0]             cand_offset_i,
  input  logic [ISSUE_W-1:0]            cand_issue_i,
  input  logic [DATA_W-1:0]             cand_data_i,
  input  logic [DEPTH-1:0]              rob_busy_i,
  input  logic [DEPTH-1:0]              rob_is_mem_i,
  input  logic [DEPTH-1:0]              rob_addr_done_i,
  input  logic [DEPTH-1:0][ISSUE_W-1:0] rob_issue_i,
  output logic                          addr_valid_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic                          addr_done_set_o,
  output logic [IDX_W-1:0]              addr_done_idx_o,
  output logic                          rob_addr_we_o,
  output logic                          rob_val_we_o,
  output logic                          rob_ready_set_o,
  output logic [IDX_W-1:0]              rob_val_idx_o,
  output logic [DATA_W-1:0]             rob_val_o
);
  logic               h_vld, h_first, pending, accept, fire;
  mem_kind_e          h_kind, in_kind;
  logic [IDX_W-1:0]   h_idx;
  logic [ADDR_W-1:0]  h_base, h_off, sum;
  logic [ISSUE_W-1:0] h_issue;
  logic [DATA_W-1:0]  h_data;

  assign in_kind = cand_is_store_i ? MEM_STORE : MEM_LOAD;
  assign accept  = cand_valid_i && !h_vld;
  assign fire    = h_vld && !pending;

  ls_cand_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ISSUE_W(ISSUE_W), .IDX_W(IDX_W)) u_hold (
    .clk_i, .rst_ni,
    .load_i(accept), .clear_i(fire),
    .kind_i(in_kind), .idx_i(cand_idx_i), .base_i(cand_base_i), .off_i(cand_offset_i),
    .issue_i(cand_issue_i), .data_i(cand_data_i),
    .vld_o(h_vld), .first_o(h_first), .kind_o(h_kind), .idx_o(h_idx),
    .base_o(h_base), .off_o(h_off), .issue_o(h_issue), .data_o(h_data)
  );

  ls_order_gate #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .IDX_W(IDX_W)) u_gate (
    .busy_i(rob_busy_i), .is_mem_i(rob_is_mem_i), .done_i(rob_addr_done_i),
    .issue_i(rob_issue_i), .own_idx_i(h_idx), .own_issue_i(h_issue),
    .pending_o(pending)
  );

  ls_eff_addr #(.ADDR_W(ADDR_W)) u_add (.base_i(h_base), .off_i(h_off), .sum_o(sum));

  assign cand_ready_o = !h_vld;

  // store value posted on first held cycle, independent of the gate
  assign rob_val_we_o    = h_vld && h_first && (h_kind == MEM_STORE);
  assign rob_ready_set_o = rob_val_we_o;
  assign rob_val_idx_o   = h_idx;
  assign rob_val_o       = h_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_valid_o    <= 1'b0;
      addr_done_set_o <= 1'b0;
      rob_addr_we_o   <= 1'b0;
      addr_o          <= '0;
      addr_done_idx_o <= '0;
    end else begin
      addr_valid_o    <= fire;
      addr_done_set_o <= fire;
      rob_addr_we_o   <= fire && (h_kind == MEM_STORE);
      if (fire) begin
        addr_o          <= sum;
        addr_done_idx_o <= h_idx;
      end
    end
  end
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cand_valid_i,
  input logic             cand_ready_o,
  input logic             cand_is_store_i,
  input logic             addr_valid_o,
  input logic             addr_done_set_o,
  input logic             rob_addr_we_o,
  input logic             rob_val_we_o,
  input logic [IDX_W-1:0] rob_val_idx_o
);
  a_r8_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i && cand_ready_o |=> !cand_ready_o);
  a_r5_store_posts_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i && cand_ready_o && cand_is_store_i |=> rob_val_we_o);
  a_r5_load_no_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i && cand_ready_o && !cand_is_store_i |=> !rob_val_we_o);
  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);
  a_r8_ready_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> cand_ready_o);
  a_r6_addr_we_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_addr_we_o |-> addr_valid_o && addr_done_set_o);
  a_r7_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_ready_o && $past(!cand_ready_o) |-> $stable(rob_val_idx_o));
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .cand_valid_i, .cand_ready_o, .cand_is_store_i,
  .addr_valid_o, .addr_done_set_o, .rob_addr_we_o, .rob_val_we_o, .rob_val_idx_o
);

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;
  localparam int DEPTH = 8, AW = 32, DW = 32, IW = 8, XW = 3;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cv = 0, cst = 0;
  logic [XW-1:0] cidx = '0;
  logic [AW-1:0] cbase = '0, coff = '0;
  logic [IW-1:0] ciss = '0;
  logic [DW-1:0] cdata = '0;
  logic [DEPTH-1:0] busy = '0, mem = '0, done = '0;
  logic [DEPTH-1:0][IW-1:0] issv = '0;

  logic crdy, av, dset, awe, vwe, rset;
  logic [AW-1:0] aout;
  logic [XW-1:0] didx, vidx;
  logic [DW-1:0] vout;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  ls_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .cand_valid_i(cv), .cand_ready_o(crdy),
    .cand_is_store_i(cst), .cand_idx_i(cidx), .cand_base_i(cbase), .cand_offset_i(coff),
    .cand_issue_i(ciss), .cand_data_i(cdata), .rob_busy_i(busy), .rob_is_mem_i(mem),
    .rob_addr_done_i(done), .rob_issue_i(issv), .addr_valid_o(av), .addr_o(aout),
    .addr_done_set_o(dset), .addr_done_idx_o(didx), .rob_addr_we_o(awe),
    .rob_val_we_o(vwe), .rob_ready_set_o(rset), .rob_val_idx_o(vidx), .rob_val_o(vout)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit blocked(logic [XW-1:0] idx, logic [IW-1:0] iss);
    for (int e = 0; e < DEPTH; e++)
      if (busy[e] && mem[e] && !done[e] && e != int'(idx) && issv[e] < iss) return 1;
    return 0;
  endfunction

  // drive at falling edge; candidate is accepted at next rising edge
  task automatic run_case(bit st, logic [XW-1:0] idx, logic [AW-1:0] b, logic [AW-1:0] o,
                          logic [IW-1:0] iss, logic [DW-1:0] d, int wait_n);
    logic [AW-1:0] exp_a = b + o;
    bit blk;
    chk("R8 ready before accept", crdy, 1);
    cv = 1; cst = st; cidx = idx; cbase = b; coff = o; ciss = iss; cdata = d;
    @(posedge clk); @(negedge clk);
    chk("R8 ready low after accept", crdy, 0);
    chk("R5 value write", vwe, st);
    chk("R5 ready mark", rset, st);
    if (st) begin
      chk("R5 value idx", vidx, idx);
      chk("R5 value data", vout, d);
    end
    chk("R4 no early valid", av, 0);
    // R7: scramble offered operands while held
    cv = 1; cst = ~st; cidx = ~idx; cbase = $urandom; coff = $urandom; ciss = $urandom; cdata = $urandom;
    blk = blocked(idx, iss);
    if (blk) begin
      for (int i = 0; i < wait_n; i++) begin
        @(posedge clk); @(negedge clk);
        chk("R3 blocked no valid", av, 0);
        chk("R5 single value write", vwe, 0);
        chk("R8 ready low while blocked", crdy, 0);
      end
      done = '1;
    end
    @(posedge clk); cv = 0; @(negedge clk);
    chk("R4 valid", av, 1);
    chk("R4 done set", dset, 1);
    chk("R4 done idx", didx, idx);
    chk("R2 address", aout, exp_a);
    chk("R6 store addr write", awe, st);
    chk("R8 ready on valid", crdy, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 pulse ends", av, 0);
    chk("R6 addr write ends", awe, 0);
  endtask

  task automatic clear_rob();
    busy = '0; mem = '0; done = '0; issv = '0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk("R1 ready in reset", crdy, 1);
    chk("R1 valid in reset", av, 0);
    chk("R1 value write in reset", vwe, 0);
    chk("R1 addr write in reset", awe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {av, dset, awe, vwe, rset}, 0);

    // directed
    clear_rob();
    run_case(1, 3'd2, 32'h1000, 32'h24, 8'd10, 32'hdead_beef, 0);
    run_case(0, 3'd5, 32'hffff_fff0, 32'h20, 8'd9, 32'h0, 0);       // R2 wrap
    // R3: older pending store blocks for 3 cycles
    clear_rob(); busy[1] = 1; mem[1] = 1; issv[1] = 8'd3;
    run_case(1, 3'd4, 32'h200, 32'h4, 8'd7, 32'h1234_5678, 3);
    // R3: equal issue does not block
    clear_rob(); busy[1] = 1; mem[1] = 1; issv[1] = 8'd7;
    run_case(0, 3'd4, 32'h300, 32'h8, 8'd7, 32'h0, 0);
    // R3: own index does not block
    clear_rob(); busy[4] = 1; mem[4] = 1; issv[4] = 8'd1;
    run_case(1, 3'd4, 32'h400, 32'hc, 8'd7, 32'haaaa_5555, 0);
    // R3: not busy / not memory / already done / younger
    clear_rob(); mem[0] = 1; issv[0] = 1;
    busy[1] = 1; issv[1] = 1;
    busy[2] = 1; mem[2] = 1; done[2] = 1; issv[2] = 1;
    busy[3] = 1; mem[3] = 1; issv[3] = 8'd200;
    run_case(0, 3'd6, 32'h500, 32'h10, 8'd50, 32'h0, 0);
    // R3: older load blocks a load
    clear_rob(); busy[7] = 1; mem[7] = 1; issv[7] = 8'd0;
    run_case(0, 3'd0, 32'h8000_0000, 32'h8000_0000, 8'd1, 32'h0, 1);

    // random
    for (int t = 0; t < 60; t++) begin
      busy = DEPTH'($urandom); mem = DEPTH'($urandom); done = DEPTH'($urandom);
      for (int e = 0; e < DEPTH; e++) issv[e] = IW'($urandom);
      run_case(1'($urandom), XW'($urandom), $urandom, $urandom, IW'($urandom),
               $urandom, 1 + int'($urandom % 3));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule